// File: doc/BRIEF.md
# Translation Table Parameter Decoder

This block turns one 64-bit base register value into the numbers a table walker needs before it touches memory: the page size in bytes, the entry size, whether the table is flat or two-level, how many entries fit in the allocated pages, how many IDs the table must cover, and the page-aligned physical base address. The same block decodes a command queue base value when `sel_cmdq` is high. Values it cannot support are flagged as a failed decode.

A register front end pulses `start` together with the value and the ID-width capabilities. The block captures them and works for a bounded number of cycles. It then raises `done` with `pass`. When the entry size is a power of two, every division is a shift and the result follows in two cycles. Any other entry size goes through a one-bit-per-cycle divider. The results stay registered until the next accepted `start`, so the front end can sample them at any time.

Top module: `xlt_param_decode`

## Requirements
- R1: After reset, `done`, `pass` and every parameter output are zero.
- R2: The page code in bits [9:8] selects the page size reported on `page_bytes_o`: 0 gives 4096, 1 gives 16384 and 2 gives 65536. Code 3 gives a failed decode (`pass`=0) and leaves every parameter output unchanged, even when the valid bit is clear.
- R3: The entry size is bits [52:48] plus one, in bytes. For a flat table (bit 62 clear), the entry count is floor((P+1)·page/esz), where P is bits [7:0].
- R4: For a two-level table (bit 62 set), the entry count is floor((P+1)·page/8) · floor(page/esz).
- R5: With 4 KB or 16 KB pages, the base address is bits [47:12] of the value kept at address bits [47:12], with the low 12 and high 4 address bits zero. With 64 KB pages, value bits [47:16] give address bits [47:16], value bits [15:12] give address bits [51:48], and the low 16 address bits are zero.
- R6: Type code 1 in bits [58:56] is a device table, and its ID count is 2^(`dev_id_bits`+1).
- R7: Type code 4 is a collection table. Its ID count is 2^(`coll_id_bits`+1) when `coll_id_lim` is 1, and 65536 otherwise.
- R8: Any other type code gives a failed decode and leaves every parameter output unchanged.
- R9: If the page code and type are supported but the valid bit 63 is clear, the decode passes and leaves every parameter output unchanged.
- R10: With `sel_cmdq`=1, the decode fails (outputs unchanged) if bit 63 is clear or bits [7:0] are zero. Otherwise the outputs are: page 4096, entry size 32, not two-level, ID count 0, entry count (P+1)·128, and a base address taken as in the 4 KB case of R5.
- R11: `done` is low in the cycle after an accepted `start` and rises no more than 32 cycles later. After that, `done`, `pass` and the outputs hold until the next `start`. A `start` that arrives while a decode is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a decode of the present inputs |
| sel_cmdq | input | 1 | 1: treat the value as a command queue base |
| base_reg | input | 64 | Base register value to decode |
| dev_id_bits | input | 5 | Device ID width minus one |
| coll_id_bits | input | 4 | Collection ID width minus one |
| coll_id_lim | input | 1 | 1: `coll_id_bits` applies |
| done | output | 1 | Decode finished; results valid |
| pass | output | 1 | Decode succeeded |
| indirect_o | output | 1 | Two-level table |
| entry_bytes_o | output | 6 | Entry size in bytes |
| page_bytes_o | output | 17 | Page size in bytes |
| max_entries_o | output | 50 | Entry capacity |
| max_ids_o | output | 33 | ID count the table must cover |
| base_addr_o | output | 52 | Page-aligned physical base |

## Verification
The bench sweeps all four page codes, all 32 entry sizes, both layouts and the smallest, a small and the largest page count. This covers every split between the shift path and the divider path. A divider with one step too few, or a two-level count that divides the total by the entry size instead of splitting it, gives wrong counts on the odd entry sizes. A design that ignores the splice would report the wrong high base bits only for 64 KB pages. Failing and valid-clear decodes are run right after a successful one, so a design that overwrites the parameters on those paths shows stale values at the ports. The collection ID fallback is exercised with the limit bit both set and clear.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   // value layout; the decoder and its users agree on these positions
   localparam int REG_W     = 64;
   localparam int PCNT_W    = 8;
   localparam int PSZ_LSB   = 8;
   localparam int AHI_LSB   = 12;
   localparam int AHI_W     = 4;
   localparam int ADDR_LSB  = 12;
   localparam int ADDR_MSB  = 47;
   localparam int ESZ_LSB   = 48;
   localparam int ESZ_W     = 5;
   localparam int TYPE_LSB  = 56;
   localparam int TYPE_W    = 3;
   localparam int IND_BIT   = 62;
   localparam int VLD_BIT   = 63;
   localparam int PA_W      = 52;
   localparam int MAX_PG_LOG = 16;
   localparam int PG_W      = MAX_PG_LOG + 1;
   localparam int TOT_W     = PCNT_W + 1 + MAX_PG_LOG;
   localparam int ENT_W     = 2 * TOT_W;
   localparam int LOG_W     = $clog2(ESZ_W + 1);

   localparam logic [TYPE_W-1:0] TT_DEVICE = 3'd1;
   localparam logic [TYPE_W-1:0] TT_COLL   = 3'd4;

   typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DIV} xlt_state_e;
endpackage

// File: rtl/xlt_fields.sv
module xlt_fields
   import xlt_pkg::*;
#(
   parameter int L1_BYTES          = 8,
   parameter int CMD_BYTES         = 32,
   parameter int DEV_BITS_W        = 5,
   parameter int COLL_BITS_W       = 4,
   parameter int COLL_DEFAULT_BITS = 16,
   parameter int ID_W              = 33
) (
   input  logic [REG_W-1:0]       raw,
   input  logic                   cmdq,
   input  logic [DEV_BITS_W-1:0]  dev_bits,
   input  logic [COLL_BITS_W-1:0] coll_bits,
   input  logic                   coll_lim,
   output logic                   bad_o,
   output logic                   keep_o,
   output logic                   ind_o,
   output logic [ESZ_W:0]         ent_bytes_o,
   output logic                   ent_pow2_o,
   output logic [LOG_W-1:0]       ent_log_o,
   output logic [PG_W-1:0]        page_bytes_o,
   output logic [TOT_W-1:0]       l1_cnt_o,
   output logic [TOT_W-1:0]       num_o,
   output logic [PA_W-1:0]        base_o,
   output logic [ID_W-1:0]        ids_o
);
   localparam int L1_LOG = $clog2(L1_BYTES);

   logic [PCNT_W-1:0] pcnt;
   logic [1:0]        code;
   logic [TYPE_W-1:0] ttype;
   logic              vld;
   logic [4:0]        pg_log;
   logic [TOT_W-1:0]  total;
   logic [PA_W-1:0]   base_flat;
   logic [PA_W-1:0]   base_wide;
   logic              unused_raw;

   assign pcnt  = raw[PCNT_W-1:0];
   assign code  = raw[PSZ_LSB +: 2];
   assign ttype = raw[TYPE_LSB +: TYPE_W];
   assign vld   = raw[VLD_BIT];
   assign unused_raw = ^{raw[11:10], raw[55:53], raw[61:59]};

   assign base_flat = {{(PA_W-ADDR_MSB-1){1'b0}}, raw[ADDR_MSB:ADDR_LSB], {ADDR_LSB{1'b0}}};
   assign base_wide = {raw[AHI_LSB +: AHI_W], raw[ADDR_MSB:MAX_PG_LOG], {MAX_PG_LOG{1'b0}}};

   always_comb begin
      bad_o       = 1'b0;
      keep_o      = 1'b0;
      ind_o       = 1'b0;
      ids_o       = '0;
      pg_log      = 5'd12;
      base_o      = base_flat;
      ent_bytes_o = (ESZ_W+1)'(CMD_BYTES);
      if (cmdq) begin
         bad_o = !vld || (pcnt == '0);
      end else begin
         ent_bytes_o = (ESZ_W+1)'(raw[ESZ_LSB +: ESZ_W]) + (ESZ_W+1)'(1);
         ind_o       = raw[IND_BIT];
         bad_o       = (code == 2'd3) || !((ttype == TT_DEVICE) || (ttype == TT_COLL));
         keep_o      = !vld;
         case (code)
            2'd1:    pg_log = 5'd14;
            2'd2:    pg_log = 5'd16;
            default: pg_log = 5'd12;
         endcase
         if (code == 2'd2) base_o = base_wide;
         if (ttype == TT_DEVICE)
            ids_o = ID_W'(1) << ({1'b0, dev_bits} + (DEV_BITS_W+1)'(1));
         else if (coll_lim)
            ids_o = ID_W'(1) << ({1'b0, coll_bits} + (COLL_BITS_W+1)'(1));
         else
            ids_o = ID_W'(1) << COLL_DEFAULT_BITS;
      end
   end

   always_comb begin
      ent_log_o = '0;
      for (int i = 0; i <= ESZ_W; i++)
         if (ent_bytes_o[i]) ent_log_o = LOG_W'(i);
   end

   assign ent_pow2_o   = ((ent_bytes_o & (ent_bytes_o - (ESZ_W+1)'(1))) == '0);
   assign page_bytes_o = PG_W'(1) << pg_log;
   assign total        = (TOT_W'(pcnt) + TOT_W'(1)) << pg_log;
   assign l1_cnt_o     = total >> L1_LOG;
   assign num_o        = ind_o ? TOT_W'(page_bytes_o) : total;
endmodule

// File: rtl/xlt_seq_div.sv
module xlt_seq_div #(
   parameter int NW = 25,
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          busy,
   output logic          fin,
   output logic [NW-1:0] quo
);
   localparam int CW = $clog2(NW + 1);

   logic [DW-1:0] rem;
   logic [NW-1:0] q;
   logic [NW-1:0] num_l;
   logic [DW-1:0] den_l;
   logic [CW-1:0] cnt;
   logic [DW:0]   trial;
   logic          ge;

   assign trial = {rem, q[NW-1]};
   assign ge    = (trial >= {1'b0, den_l});
   assign quo   = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0; q <= '0; num_l <= '0; den_l <= '0;
         cnt <= '0; busy <= 1'b0; fin <= 1'b0;
      end else if (go) begin
         rem   <= '0;
         q     <= num;
         num_l <= num;
         den_l <= den;
         cnt   <= CW'(NW);
         busy  <= 1'b1;
         fin   <= 1'b0;
      end else if (busy) begin
         rem <= ge ? DW'(trial - {1'b0, den_l}) : trial[DW-1:0];
         q   <= {q[NW-2:0], ge};
         cnt <= cnt - CW'(1);
         if (cnt == CW'(1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   logic [NW+DW-1:0] prod;
   assign prod = (NW+DW)'(q) * (NW+DW)'(den_l);

   // R3 / R4: quotient is exact floor division
   a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (prod <= (NW+DW)'(num_l)) && (((NW+DW)'(num_l) - prod) < (NW+DW)'(den_l)));
   a_r3_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (den != '0));
endmodule

// File: rtl/xlt_param_decode.sv
module xlt_param_decode
   import xlt_pkg::*;
#(
   parameter int L1_BYTES          = 8,
   parameter int CMD_BYTES         = 32,
   parameter int DEV_BITS_W        = 5,
   parameter int COLL_BITS_W       = 4,
   parameter int COLL_DEFAULT_BITS = 16,
   localparam int ID_BIG = (2**DEV_BITS_W > 2**COLL_BITS_W) ? 2**DEV_BITS_W : 2**COLL_BITS_W,
   localparam int ID_W   = ((ID_BIG > COLL_DEFAULT_BITS) ? ID_BIG : COLL_DEFAULT_BITS) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   sel_cmdq,
   input  logic [REG_W-1:0]       base_reg,
   input  logic [DEV_BITS_W-1:0]  dev_id_bits,
   input  logic [COLL_BITS_W-1:0] coll_id_bits,
   input  logic                   coll_id_lim,
   output logic                   done,
   output logic                   pass,
   output logic                   indirect_o,
   output logic [ESZ_W:0]         entry_bytes_o,
   output logic [PG_W-1:0]        page_bytes_o,
   output logic [ENT_W-1:0]       max_entries_o,
   output logic [ID_W-1:0]        max_ids_o,
   output logic [PA_W-1:0]        base_addr_o
);
   localparam int MAX_LAT = TOT_W + 4;
   localparam int LC_W    = $clog2(MAX_LAT + 2);

   if ((L1_BYTES & (L1_BYTES - 1)) != 0 || L1_BYTES < 1) begin : g_bad_l1
      $error("L1_BYTES must be a power of two");
   end
   if ((CMD_BYTES & (CMD_BYTES - 1)) != 0 || CMD_BYTES > 2**ESZ_W) begin : g_bad_cmd
      $error("CMD_BYTES must be a power of two no larger than the entry field range");
   end
   if (COLL_DEFAULT_BITS < 1 || DEV_BITS_W < 1 || COLL_BITS_W < 1) begin : g_bad_id
      $error("ID width parameters must be positive");
   end

   xlt_state_e             state;
   logic [REG_W-1:0]       s_raw;
   logic                   s_cmd;
   logic [DEV_BITS_W-1:0]  s_dev;
   logic [COLL_BITS_W-1:0] s_coll;
   logic                   s_lim;

   logic                   f_bad, f_keep, f_ind, f_pow2;
   logic [ESZ_W:0]         f_esz;
   logic [LOG_W-1:0]       f_log;
   logic [PG_W-1:0]        f_page;
   logic [TOT_W-1:0]       f_l1, f_num;
   logic [PA_W-1:0]        f_base;
   logic [ID_W-1:0]        f_ids;

   logic                   div_go, div_busy, div_fin;
   logic [TOT_W-1:0]       div_q, q_sel;
   logic [ENT_W-1:0]       ent_calc;
   logic                   commit;
   logic [LC_W-1:0]        lat_cnt;

   xlt_fields #(
      .L1_BYTES(L1_BYTES), .CMD_BYTES(CMD_BYTES), .DEV_BITS_W(DEV_BITS_W),
      .COLL_BITS_W(COLL_BITS_W), .COLL_DEFAULT_BITS(COLL_DEFAULT_BITS), .ID_W(ID_W)
   ) u_fields (
      .raw(s_raw), .cmdq(s_cmd), .dev_bits(s_dev), .coll_bits(s_coll), .coll_lim(s_lim),
      .bad_o(f_bad), .keep_o(f_keep), .ind_o(f_ind), .ent_bytes_o(f_esz),
      .ent_pow2_o(f_pow2), .ent_log_o(f_log), .page_bytes_o(f_page),
      .l1_cnt_o(f_l1), .num_o(f_num), .base_o(f_base), .ids_o(f_ids)
   );

   assign div_go = (state == ST_EVAL) && !f_bad && !f_keep && !f_pow2;

   xlt_seq_div #(.NW(TOT_W), .DW(ESZ_W+1)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(f_num), .den(f_esz),
      .busy(div_busy), .fin(div_fin), .quo(div_q)
   );

   assign q_sel    = (state == ST_DIV) ? div_q : (f_num >> f_log);
   assign ent_calc = f_ind ? (ENT_W'(f_l1) * ENT_W'(q_sel)) : ENT_W'(q_sel);
   assign commit   = ((state == ST_EVAL) && !f_bad && !f_keep && f_pow2) ||
                     ((state == ST_DIV) && div_fin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         s_raw <= '0; s_cmd <= 1'b0; s_dev <= '0; s_coll <= '0; s_lim <= 1'b0;
         done <= 1'b0; pass <= 1'b0;
         indirect_o <= 1'b0; entry_bytes_o <= '0; page_bytes_o <= '0;
         max_entries_o <= '0; max_ids_o <= '0; base_addr_o <= '0;
      end else begin
         if (commit) begin
            indirect_o    <= f_ind;
            entry_bytes_o <= f_esz;
            page_bytes_o  <= f_page;
            max_entries_o <= ent_calc;
            max_ids_o     <= f_ids;
            base_addr_o   <= f_base;
         end
         case (state)
            ST_IDLE: if (start) begin
               s_raw  <= base_reg;
               s_cmd  <= sel_cmdq;
               s_dev  <= dev_id_bits;
               s_coll <= coll_id_bits;
               s_lim  <= coll_id_lim;
               done   <= 1'b0;
               state  <= ST_EVAL;
            end
            ST_EVAL: begin
               if (f_bad || f_keep || f_pow2) begin
                  done  <= 1'b1;
                  pass  <= !f_bad;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_DIV;
               end
            end
            ST_DIV: if (div_fin) begin
               done  <= 1'b1;
               pass  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (state == ST_IDLE) lat_cnt <= '0;
      else                       lat_cnt <= lat_cnt + LC_W'(1);
   end

   // R11: an accepted start clears done on the next cycle
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> !done);
   // R11: results and status hold while no start arrives
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(pass) && $stable(max_entries_o) &&
                            $stable(base_addr_o) && $stable(max_ids_o) && $stable(page_bytes_o)));
   // R11: bounded decode time
   a_r11_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      lat_cnt <= LC_W'(MAX_LAT));
   // R8: a failing decode does not touch the parameters
   a_r8_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !pass) |-> ($stable(max_entries_o) && $stable(base_addr_o) &&
                                  $stable(max_ids_o) && $stable(entry_bytes_o)));
   // R2: the reported page size is a single power of two
   a_r2_page_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(page_bytes_o));
   // R3: divider is only started from the evaluate step when idle
   a_r3_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |-> !div_busy);
endmodule

// File: tb/sim_xlt_param_decode.sv
module sim_xlt_param_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sel_cmdq = 1'b0;
   logic [63:0] base_reg = '0;
   logic [4:0]  dev_id_bits = '0;
   logic [3:0]  coll_id_bits = '0;
   logic        coll_id_lim = 1'b0;
   logic        done, pass, indirect_o;
   logic [5:0]  entry_bytes_o;
   logic [16:0] page_bytes_o;
   logic [49:0] max_entries_o;
   logic [32:0] max_ids_o;
   logic [51:0] base_addr_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [63:0] e_pass = 0, e_ind = 0, e_esz = 0, e_page = 0, e_ent = 0, e_ids = 0, e_base = 0;

   xlt_param_decode u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sel_cmdq(sel_cmdq), .base_reg(base_reg),
      .dev_id_bits(dev_id_bits), .coll_id_bits(coll_id_bits), .coll_id_lim(coll_id_lim),
      .done(done), .pass(pass), .indirect_o(indirect_o), .entry_bytes_o(entry_bytes_o),
      .page_bytes_o(page_bytes_o), .max_entries_o(max_entries_o), .max_ids_o(max_ids_o),
      .base_addr_o(base_addr_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      chk(req, "done", 64'(done), 64'd1);
      chk(req, "pass", 64'(pass), e_pass);
      chk(req, "indirect", 64'(indirect_o), e_ind);
      chk(req, "entry_bytes", 64'(entry_bytes_o), e_esz);
      chk(req, "page_bytes", 64'(page_bytes_o), e_page);
      chk(req, "max_entries", 64'(max_entries_o), e_ent);
      chk(req, "max_ids", 64'(max_ids_o), e_ids);
      chk(req, "base_addr", 64'(base_addr_o), e_base);
   endtask

   task automatic do_decode(input logic [63:0] v, input logic cmd, input logic [4:0] db,
                            input logic [3:0] cb, input logic cl);
      int n;
      @(negedge clk);
      base_reg = v; sel_cmdq = cmd; dev_id_bits = db; coll_id_bits = cb; coll_id_lim = cl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "done after start", 64'(done), 64'd0);
      n = 0;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R11", "latency bound", 64'(n <= 32), 64'd1);
   endtask

   // table decode with model update; tag names the requirement targeted
   task automatic run_table(input logic vld, input logic ind, input logic [2:0] typ,
                            input logic [4:0] esf, input logic [1:0] pc, input logic [7:0] pcnt,
                            input logic [35:0] addr, input logic [4:0] db, input logic [3:0] cb,
                            input logic cl, input string req);
      logic [63:0] v;
      longint unsigned page, total, esz;
      v = '0;
      v[63] = vld; v[62] = ind; v[58:56] = typ; v[52:48] = esf;
      v[47:12] = addr; v[9:8] = pc; v[7:0] = pcnt;
      if (pc == 2'd3 || !(typ == 3'd1 || typ == 3'd4)) begin
         e_pass = 0;
      end else if (!vld) begin
         e_pass = 1;
      end else begin
         page  = 64'd1 << (12 + 2 * pc);
         total = (64'(pcnt) + 1) * page;
         esz   = 64'(esf) + 1;
         e_pass = 1;
         e_ind  = 64'(ind);
         e_esz  = esz;
         e_page = page;
         e_ent  = ind ? (total / 8) * (page / esz) : total / esz;
         if (typ == 3'd1)  e_ids = 64'd1 << (db + 1);
         else if (cl)      e_ids = 64'd1 << (cb + 1);
         else              e_ids = 64'd1 << 16;
         if (pc == 2'd2) e_base = {12'h0, addr[3:0], addr[35:4], 16'h0};
         else            e_base = {16'h0, addr, 12'h0};
      end
      do_decode(v, 1'b0, db, cb, cl);
      compare_all(req);
   endtask

   task automatic run_cmdq(input logic vld, input logic [7:0] pcnt, input logic [35:0] addr);
      logic [63:0] v;
      v = '0;
      v[63] = vld; v[47:12] = addr; v[7:0] = pcnt;
      v[9:8] = 2'd2; v[62] = 1'b1; v[52:48] = 5'd6; v[58:56] = 3'd7;
      if (!vld || pcnt == 8'd0) begin
         e_pass = 0;
      end else begin
         e_pass = 1; e_ind = 0; e_esz = 32; e_page = 4096; e_ids = 0;
         e_ent  = (64'(pcnt) + 1) * 128;
         e_base = {16'h0, addr, 12'h0};
      end
      do_decode(v, 1'b1, 5'd3, 4'd3, 1'b1);
      compare_all("R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "done", 64'(done), 0);
      chk("R1", "pass", 64'(pass), 0);
      chk("R1", "max_entries", 64'(max_entries_o), 0);
      chk("R1", "base_addr", 64'(base_addr_o), 0);
      chk("R1", "page_bytes", 64'(page_bytes_o), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7: sweep of page codes, entry sizes, layouts and page counts
      for (int pc = 0; pc < 4; pc++) begin
         for (int esf = 0; esf < 32; esf++) begin
            for (int ind = 0; ind < 2; ind++) begin
               for (int k = 0; k < 3; k++) begin
                  logic [7:0]  pcnt;
                  logic [35:0] addr;
                  logic [2:0]  typ;
                  pcnt = (k == 0) ? 8'd0 : (k == 1) ? 8'd3 : 8'd255;
                  addr = 36'h5_A3C9_1E07 + 36'(esf) * 36'h1_0103 + 36'(pc * 5 + k);
                  typ  = esf[0] ? 3'd1 : 3'd4;
                  run_table(1'b1, ind[0], typ, esf[4:0], pc[1:0], pcnt, addr,
                            esf[4:0], esf[3:0], esf[1], (pc == 3) ? "R2" : (ind != 0) ? "R4" : "R3");
               end
            end
         end
      end

      // R7: collection fallback and limit, R6: widest device ID
      run_table(1'b1, 1'b0, 3'd4, 5'd7, 2'd0, 8'd1, 36'h1_2345_6789, 5'd0, 4'd15, 1'b0, "R7");
      run_table(1'b1, 1'b0, 3'd4, 5'd7, 2'd0, 8'd1, 36'h1_2345_6789, 5'd0, 4'd2, 1'b1, "R7");
      run_table(1'b1, 1'b0, 3'd1, 5'd3, 2'd2, 8'd9, 36'hF_0000_000A, 5'd31, 4'd0, 1'b0, "R6");
      run_table(1'b1, 1'b1, 3'd1, 5'd3, 2'd2, 8'd9, 36'h8_1234_5675, 5'd0, 4'd0, 1'b0, "R5");

      // R8: unsupported type codes after a good decode
      for (int t = 0; t < 8; t++) begin
         if (t != 1 && t != 4)
            run_table(1'b1, 1'b0, t[2:0], 5'd1, 2'd1, 8'd2, 36'h3_3333_3333, 5'd2, 4'd2, 1'b1, "R8");
      end

      // R9: valid clear passes without update; R2: code 3 still fails when invalid
      run_table(1'b0, 1'b1, 3'd4, 5'd10, 2'd0, 8'd77, 36'h7_7777_7777, 5'd9, 4'd9, 1'b1, "R9");
      run_table(1'b0, 1'b0, 3'd1, 5'd2, 2'd1, 8'd5, 36'h2_2222_2222, 5'd4, 4'd1, 1'b0, "R9");
      run_table(1'b0, 1'b0, 3'd1, 5'd2, 2'd3, 8'd5, 36'h2_2222_2222, 5'd4, 4'd1, 1'b0, "R2");

      // R10: command queue
      run_cmdq(1'b1, 8'd1, 36'h9_8765_4321);
      run_cmdq(1'b0, 8'd4, 36'h1_1111_1111);
      run_cmdq(1'b1, 8'd0, 36'h1_1111_1111);
      run_cmdq(1'b1, 8'd255, 36'hA_BCDE_F012);
      run_cmdq(1'b1, 8'd17, 36'h0_0000_1000);

      // R11: outputs hold while idle
      repeat (5) @(negedge clk);
      compare_all("R11");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule